// File: doc/BRIEF.md
# Conflict-Checking Set Claim Arbiter

The arbiter hands out a whole command set to an immediate-mode request. It holds an in-use bit for every set, and it keeps a copy of each set's command addresses and their enable bits. A program port fills that copy. When a request arrives with up to `MAX_REQ` target addresses, the arbiter walks through every command slot of the sets in its active group, one slot per cycle. Each stored address is compared against all request addresses in parallel. If an in-use set holds an enabled command that aims at any of those addresses, the answer is busy. Otherwise the lowest free set in the group is granted. A full group also answers busy. After a busy answer the requester tries again.

The active group is a parameter choice. Normally it is the immediate group. When that group is configured with no sets, the arbiter borrows the wake group instead. Granting a borrowed set wipes the command enables left over from its wake programming and turns on its completion interrupt. A completion input releases a set: its enables are cleared, an interrupt-status acknowledge strobe is issued, and the tag stored at grant time is returned. For a borrowed set the completion also pulses a mode/trigger clear strobe and masks its interrupt again. A level output reports whether any set of the active group is still held.

Top module: `set_claim_arbiter`

## Requirements
- R1: After reset no set is held, `reqReady` is 1, `doneValid` and `groupBusy` are 0, and `irqEn` equals the immediate group's set mask (all zero when the group is being borrowed).
- R2: Only sets from the active group's offset up to offset plus count minus one are scanned or granted; the active group is the immediate group, or the wake group when the immediate count is 0.
- R3: A request is answered busy (`doneGrant`=0) when any held set of the active group has an enabled command, as written by the program port (`progValid` sets slot `progSlot` of set `progSet` enabled with address `progAddr`), whose address equals one of the first `reqCount` request addresses; addresses at positions `reqCount` and above are ignored.
- R4: Without a conflict the lowest-numbered free set of the active group is granted (`doneGrant`=1, `doneSet`); when every set of the group is held the answer is busy.
- R5: A grant marks the set held and stores `reqTag` against it; the completion of that set returns the tag on `relTag`.
- R6: `cplValid` for set `cplSet` releases the set and clears its command enables; one cycle later `relValid` and bit `cplSet` of `irqAck` pulse.
- R7: When borrowing, a grant clears the granted set's command enables and sets its `irqEn` bit.
- R8: When borrowing, the completion of a set clears its `irqEn` bit and pulses bit `cplSet` of `modeClr` one cycle later; without borrowing `modeClr` stays 0 and `irqEn` stays constant.
- R9: A request is accepted only while `reqReady` is 1; `reqReady` then drops, and exactly GROUP_SETS x CMDS_PER_SET + 1 cycles after the accepting edge a one-cycle `doneValid` pulse carries the answer and `reqReady` returns; `reqValid` while `reqReady` is 0 is ignored.
- R10: `groupBusy` is 1 exactly when a set of the active group is held.
- R11: A completion at the same edge as a decision does not free a set for that decision, but takes effect for the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe |
| reqReady | output | 1 | Arbiter idle and able to take a request |
| reqCount | input | $clog2(MAX_REQ+1) | Number of valid request addresses |
| reqAddrs | input | MAX_REQ*ADDR_W | Request addresses, entry k at bits k*ADDR_W upward |
| reqTag | input | TAG_W | Tag stored against the granted set |
| progValid | input | 1 | Write one stored command address and enable it |
| progSet | input | $clog2(NUM_SETS) | Set written |
| progSlot | input | $clog2(CMDS_PER_SET) | Slot written |
| progAddr | input | ADDR_W | Address written |
| cplValid | input | 1 | Completion strobe |
| cplSet | input | $clog2(NUM_SETS) | Set completed |
| doneValid | output | 1 | Answer pulse |
| doneGrant | output | 1 | 1 = granted, 0 = busy |
| doneSet | output | $clog2(NUM_SETS) | Granted set (0 when busy) |
| groupBusy | output | 1 | Some set of the active group held |
| irqEn | output | NUM_SETS | Per-set completion interrupt enable |
| relValid | output | 1 | Completion acknowledged |
| relTag | output | TAG_W | Tag of the completed set |
| irqAck | output | NUM_SETS | One-hot interrupt status clear pulse |
| modeClr | output | NUM_SETS | One-hot mode/trigger clear pulse for borrowed sets |

## Verification
The answer to a request is due exactly GROUP_SETS x CMDS_PER_SET + 1 edges after the accepting edge: nine for the default immediate group and thirteen for the borrowed wake group. The bench counts edges from the accepting edge, samples at each following falling edge, and demands `doneValid` low on every edge but the due one and `reqReady` low until it. Completion outputs and the clearing of enables and interrupt masks are due one edge after `cplValid`, and `groupBusy` follows the held bits at the same edge, so those are sampled at the falling edge right after the completion edge. A stray request pulse is sent mid-scan on every request so the edge count also shows it was ignored.

// File: rtl/set_claim_pkg.sv
package set_claim_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SCAN   = 2'd1,
    ST_DECIDE = 2'd2
  } arb_state_e;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic latchReq;  // capture the request fields
    logic scanEn;    // compare the slot at scanSet/scanSlot
    logic decide;    // resolve grant or busy this edge
  } arb_strobe_t;

endpackage

// File: rtl/sca_control.sv
module sca_control
  import set_claim_pkg::*;
#(
  parameter int NUM_SETS     = 8,
  parameter int CMDS_PER_SET = 4,
  parameter int GRP_OFF      = 0,
  parameter int GRP_N        = 2,
  localparam int SW = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int CW = (CMDS_PER_SET > 1) ? $clog2(CMDS_PER_SET) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  output arb_strobe_t   strobe,
  output logic [SW-1:0] scanSet,
  output logic [CW-1:0] scanSlot
);

  localparam int LAST_SET = GRP_OFF + GRP_N - 1;

  arb_state_e    state;
  logic [SW-1:0] setIdx;
  logic [CW-1:0] slotIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      setIdx  <= '0;
      slotIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state   <= ST_SCAN;
            setIdx  <= SW'(GRP_OFF);
            slotIdx <= '0;
          end
        end
        ST_SCAN: begin
          if (slotIdx == CW'(CMDS_PER_SET - 1)) begin
            slotIdx <= '0;
            if (setIdx == SW'(LAST_SET)) state <= ST_DECIDE;
            else                         setIdx <= setIdx + 1'b1;
          end else begin
            slotIdx <= slotIdx + 1'b1;
          end
        end
        ST_DECIDE: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.latchReq = (state == ST_IDLE) && reqValid;
    strobe.scanEn   = (state == ST_SCAN);
    strobe.decide   = (state == ST_DECIDE);
  end

  assign reqReady = (state == ST_IDLE);
  assign scanSet  = setIdx;
  assign scanSlot = slotIdx;

  // R2: the scan never leaves the active group
  p_scan_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN) |-> (setIdx <= SW'(LAST_SET)));

  // R9: an accepted request takes the arbiter out of the ready state
  p_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid) |=> !reqReady);

endmodule

// File: rtl/sca_datapath.sv
module sca_datapath
  import set_claim_pkg::*;
#(
  parameter int NUM_SETS     = 8,
  parameter int CMDS_PER_SET = 4,
  parameter int ADDR_W       = 16,
  parameter int MAX_REQ      = 16,
  parameter int TAG_W        = 8,
  parameter int GRP_OFF      = 0,
  parameter int GRP_N        = 2,
  parameter bit BORROW       = 1'b0,
  localparam int SW   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int CW   = (CMDS_PER_SET > 1) ? $clog2(CMDS_PER_SET) : 1,
  localparam int CNTW = $clog2(MAX_REQ + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  arb_strobe_t               strobe,
  input  logic [SW-1:0]             scanSet,
  input  logic [CW-1:0]             scanSlot,
  input  logic [CNTW-1:0]           reqCount,
  input  logic [MAX_REQ*ADDR_W-1:0] reqAddrs,
  input  logic [TAG_W-1:0]          reqTag,
  input  logic                      progValid,
  input  logic [SW-1:0]             progSet,
  input  logic [CW-1:0]             progSlot,
  input  logic [ADDR_W-1:0]         progAddr,
  input  logic                      cplValid,
  input  logic [SW-1:0]             cplSet,
  output logic                      doneValid,
  output logic                      doneGrant,
  output logic [SW-1:0]             doneSet,
  output logic                      groupBusy,
  output logic [NUM_SETS-1:0]       irqEn,
  output logic                      relValid,
  output logic [TAG_W-1:0]          relTag,
  output logic [NUM_SETS-1:0]       irqAck,
  output logic [NUM_SETS-1:0]       modeClr
);

  localparam logic [NUM_SETS-1:0] GRP_MASK =
    NUM_SETS'(((64'd1 << GRP_N) - 64'd1) << GRP_OFF);
  localparam logic [NUM_SETS-1:0] IRQ_INIT = BORROW ? '0 : GRP_MASK;

  // stored command copy and per-set state
  logic [ADDR_W-1:0]       cmdAddr [NUM_SETS][CMDS_PER_SET];
  logic [CMDS_PER_SET-1:0] cmdEn   [NUM_SETS];
  logic [TAG_W-1:0]        setTag  [NUM_SETS];
  logic [NUM_SETS-1:0]     inUse;

  // latched request
  logic [ADDR_W-1:0] lAddr [MAX_REQ];
  logic [CNTW-1:0]   lCount;
  logic [TAG_W-1:0]  lTag;
  logic              conflict;

  // ---------------- request latch ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lCount <= '0;
      lTag   <= '0;
      for (int k = 0; k < MAX_REQ; k++) lAddr[k] <= '0;
    end else if (strobe.latchReq) begin
      lCount <= reqCount;
      lTag   <= reqTag;
      for (int k = 0; k < MAX_REQ; k++) lAddr[k] <= reqAddrs[k*ADDR_W +: ADDR_W];
    end
  end

  // ---------------- one slot against all request addresses ----------------
  logic [MAX_REQ-1:0] addrHit;
  logic [ADDR_W-1:0]  slotAddr;
  logic               slotLive;
  logic               scanHit;

  assign slotAddr = cmdAddr[scanSet][scanSlot];
  assign slotLive = inUse[scanSet] && cmdEn[scanSet][scanSlot];

  for (genvar k = 0; k < MAX_REQ; k++) begin : g_cmp
    assign addrHit[k] = (CNTW'(k) < lCount) && (lAddr[k] == slotAddr);
  end

  assign scanHit = slotLive && (|addrHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          conflict <= 1'b0;
    else if (strobe.latchReq)           conflict <= 1'b0;
    else if (strobe.scanEn && scanHit)  conflict <= 1'b1;
  end

  // ---------------- lowest free set in the group ----------------
  logic          freeFound;
  logic [SW-1:0] freeSet;

  always_comb begin
    freeFound = 1'b0;
    freeSet   = '0;
    for (int i = GRP_OFF + GRP_N - 1; i >= GRP_OFF; i--) begin
      if (!inUse[i]) begin
        freeFound = 1'b1;
        freeSet   = SW'(i);
      end
    end
  end

  logic                grantNow;
  logic [NUM_SETS-1:0] grantMask;
  logic [NUM_SETS-1:0] cplMask;

  assign grantNow  = strobe.decide && !conflict && freeFound;
  assign grantMask = grantNow ? (NUM_SETS'(1) << freeSet) : '0;
  assign cplMask   = cplValid ? (NUM_SETS'(1) << cplSet) : '0;

  // ---------------- held bits and tags ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inUse <= '0;
      for (int s = 0; s < NUM_SETS; s++) setTag[s] <= '0;
    end else begin
      inUse <= (inUse & ~cplMask) | grantMask;
      if (grantNow) setTag[freeSet] <= lTag;
    end
  end

  // ---------------- stored commands ----------------
  always_ff @(posedge clk) begin
    if (progValid) cmdAddr[progSet][progSlot] <= progAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) cmdEn[s] <= '0;
    end else begin
      for (int s = 0; s < NUM_SETS; s++) begin
        if (cplMask[s] || (BORROW && grantMask[s])) cmdEn[s] <= '0;
        else if (progValid && (progSet == SW'(s))) cmdEn[s][progSlot] <= 1'b1;
      end
    end
  end

  // ---------------- interrupts and completion strobes ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEn    <= IRQ_INIT;
      irqAck   <= '0;
      modeClr  <= '0;
      relValid <= 1'b0;
      relTag   <= '0;
    end else begin
      if (BORROW) irqEn <= (irqEn & ~cplMask) | grantMask;
      irqAck   <= cplMask;
      modeClr  <= BORROW ? cplMask : '0;
      relValid <= cplValid;
      relTag   <= setTag[cplSet];
    end
  end

  // ---------------- answer ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneValid <= 1'b0;
      doneGrant <= 1'b0;
      doneSet   <= '0;
    end else begin
      doneValid <= strobe.decide;
      doneGrant <= grantNow;
      doneSet   <= grantNow ? freeSet : '0;
    end
  end

  assign groupBusy = |(inUse & GRP_MASK);

  // R2: a granted set lies inside the active group
  p_grant_in_group_r2: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneGrant) |-> GRP_MASK[doneSet]);

  // R4: a granted set was free before and is held now
  p_grant_was_free_r4: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneGrant) |->
      (inUse[doneSet] && (($past(inUse) & (NUM_SETS'(1) << doneSet)) == '0)));

  // R6: a completed held set is released
  p_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cplValid && inUse[cplSet]) |=> !inUse[$past(cplSet)]);

  // R9: the answer is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  if (BORROW) begin : g_borrow_chk
    // R7: a borrowed set starts with no stale enables and its interrupt on
    p_borrow_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
      (doneValid && doneGrant) |-> ((cmdEn[doneSet] == '0) && irqEn[doneSet]));

    // R8: a completed borrowed set is masked again
    p_borrow_mask_r8: assert property (@(posedge clk) disable iff (!rstN)
      (cplValid && inUse[cplSet]) |=> (!irqEn[$past(cplSet)] && modeClr[$past(cplSet)]));
  end else begin : g_own_chk
    // R8: without borrowing the interrupt enables never move
    p_irq_fixed_r8: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> $stable(irqEn));
  end

endmodule

// File: rtl/set_claim_arbiter.sv
module set_claim_arbiter
  import set_claim_pkg::*;
#(
  parameter int NUM_SETS     = 8,
  parameter int CMDS_PER_SET = 4,
  parameter int ADDR_W       = 16,
  parameter int MAX_REQ      = 16,
  parameter int TAG_W        = 8,
  parameter int IMM_OFF      = 0,
  parameter int IMM_N        = 2,
  parameter int WAKE_OFF     = 2,
  parameter int WAKE_N       = 3,
  localparam int SW   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int CW   = (CMDS_PER_SET > 1) ? $clog2(CMDS_PER_SET) : 1,
  localparam int CNTW = $clog2(MAX_REQ + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  output logic                      reqReady,
  input  logic [CNTW-1:0]           reqCount,
  input  logic [MAX_REQ*ADDR_W-1:0] reqAddrs,
  input  logic [TAG_W-1:0]          reqTag,
  input  logic                      progValid,
  input  logic [SW-1:0]             progSet,
  input  logic [CW-1:0]             progSlot,
  input  logic [ADDR_W-1:0]         progAddr,
  input  logic                      cplValid,
  input  logic [SW-1:0]             cplSet,
  output logic                      doneValid,
  output logic                      doneGrant,
  output logic [SW-1:0]             doneSet,
  output logic                      groupBusy,
  output logic [NUM_SETS-1:0]       irqEn,
  output logic                      relValid,
  output logic [TAG_W-1:0]          relTag,
  output logic [NUM_SETS-1:0]       irqAck,
  output logic [NUM_SETS-1:0]       modeClr
);

  localparam bit BORROW  = (IMM_N == 0);
  localparam int GRP_OFF = BORROW ? WAKE_OFF : IMM_OFF;
  localparam int GRP_N   = BORROW ? WAKE_N : IMM_N;

  arb_strobe_t   strobe;
  logic [SW-1:0] scanSet;
  logic [CW-1:0] scanSlot;

  sca_control #(
    .NUM_SETS    (NUM_SETS),
    .CMDS_PER_SET(CMDS_PER_SET),
    .GRP_OFF     (GRP_OFF),
    .GRP_N       (GRP_N)
  ) u_control (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .strobe  (strobe),
    .scanSet (scanSet),
    .scanSlot(scanSlot)
  );

  sca_datapath #(
    .NUM_SETS    (NUM_SETS),
    .CMDS_PER_SET(CMDS_PER_SET),
    .ADDR_W      (ADDR_W),
    .MAX_REQ     (MAX_REQ),
    .TAG_W       (TAG_W),
    .GRP_OFF     (GRP_OFF),
    .GRP_N       (GRP_N),
    .BORROW      (BORROW)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .scanSet  (scanSet),
    .scanSlot (scanSlot),
    .reqCount (reqCount),
    .reqAddrs (reqAddrs),
    .reqTag   (reqTag),
    .progValid(progValid),
    .progSet  (progSet),
    .progSlot (progSlot),
    .progAddr (progAddr),
    .cplValid (cplValid),
    .cplSet   (cplSet),
    .doneValid(doneValid),
    .doneGrant(doneGrant),
    .doneSet  (doneSet),
    .groupBusy(groupBusy),
    .irqEn    (irqEn),
    .relValid (relValid),
    .relTag   (relTag),
    .irqAck   (irqAck),
    .modeClr  (modeClr)
  );

endmodule

// File: tb/set_claim_arbiter_bench.sv
`timescale 1ns/1ps
module set_claim_arbiter_bench;

  localparam int SETS = 8;
  localparam int CPS  = 4;
  localparam int NREQ = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic          reqValid = 0;
  logic [4:0]    reqCount = 0;
  logic [255:0]  reqAddrs = '0;
  logic [7:0]    reqTag = 0;
  logic          progValid = 0;
  logic [2:0]    progSet = 0;
  logic [1:0]    progSlot = 0;
  logic [15:0]   progAddr = 0;
  logic          cplValid = 0;
  logic [2:0]    cplSet = 0;

  logic       reqReadyX  [2];
  logic       doneValidX [2];
  logic       doneGrantX [2];
  logic [2:0] doneSetX   [2];
  logic       groupBusyX [2];
  logic [7:0] irqEnX     [2];
  logic       relValidX  [2];
  logic [7:0] relTagX    [2];
  logic [7:0] irqAckX    [2];
  logic [7:0] modeClrX   [2];

  // instance 0: own immediate group (sets 0..1); instance 1: borrows wake sets 2..4
  set_claim_arbiter u_set_claim_arbiter (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReadyX[0]),
    .reqCount(reqCount), .reqAddrs(reqAddrs), .reqTag(reqTag),
    .progValid(progValid), .progSet(progSet), .progSlot(progSlot), .progAddr(progAddr),
    .cplValid(cplValid), .cplSet(cplSet),
    .doneValid(doneValidX[0]), .doneGrant(doneGrantX[0]), .doneSet(doneSetX[0]),
    .groupBusy(groupBusyX[0]), .irqEn(irqEnX[0]), .relValid(relValidX[0]),
    .relTag(relTagX[0]), .irqAck(irqAckX[0]), .modeClr(modeClrX[0]));

  set_claim_arbiter #(.IMM_N(0)) u_set_claim_arbiter_borrow (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReadyX[1]),
    .reqCount(reqCount), .reqAddrs(reqAddrs), .reqTag(reqTag),
    .progValid(progValid), .progSet(progSet), .progSlot(progSlot), .progAddr(progAddr),
    .cplValid(cplValid), .cplSet(cplSet),
    .doneValid(doneValidX[1]), .doneGrant(doneGrantX[1]), .doneSet(doneSetX[1]),
    .groupBusy(groupBusyX[1]), .irqEn(irqEnX[1]), .relValid(relValidX[1]),
    .relTag(relTagX[1]), .irqAck(irqAckX[1]), .modeClr(modeClrX[1]));

  int gOff   [2] = '{0, 2};
  int gN     [2] = '{2, 3};
  int lat    [2] = '{9, 13};
  bit borrow [2] = '{0, 1};

  bit          mInUse [2][SETS];
  bit          mEn    [2][SETS][CPS];
  bit          mIrq   [2][SETS];
  logic [7:0]  mTag   [2][SETS];
  logic [15:0] mAddr  [SETS][CPS];
  logic [15:0] rq     [NREQ];

  int nChecks = 0;
  int nFail   = 0;
  int unsigned seed = 32'h1234_5678;

  function automatic int unsigned nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return (seed >> 8);
  endfunction

  task automatic checkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic checkState();
    for (int i = 0; i < 2; i++) begin
      bit busy = 0;
      int irq = 0;
      for (int s = gOff[i]; s < gOff[i] + gN[i]; s++) if (mInUse[i][s]) busy = 1;
      for (int s = 0; s < SETS; s++) if (mIrq[i][s]) irq |= (1 << s);
      checkEq($sformatf("R10 groupBusy inst%0d", i), int'(groupBusyX[i]), int'(busy));
      checkEq($sformatf("R7/R8 irqEn inst%0d", i), int'(irqEnX[i]), irq);
    end
  endtask

  task automatic applyCpl(input int s);
    for (int i = 0; i < 2; i++) begin
      checkEq($sformatf("R6 relValid inst%0d", i), int'(relValidX[i]), 1);
      checkEq($sformatf("R6 irqAck inst%0d", i), int'(irqAckX[i]), 1 << s);
      checkEq($sformatf("R8 modeClr inst%0d", i), int'(modeClrX[i]), borrow[i] ? (1 << s) : 0);
      if (mInUse[i][s])
        checkEq($sformatf("R5 relTag inst%0d", i), int'(relTagX[i]), int'(mTag[i][s]));
      mInUse[i][s] = 0;
      for (int sl = 0; sl < CPS; sl++) mEn[i][s][sl] = 0;
      if (borrow[i]) mIrq[i][s] = 0;
    end
  endtask

  task automatic doComplete(input int s);
    @(negedge clk);
    cplValid = 1; cplSet = 3'(s);
    @(posedge clk); @(negedge clk);
    cplValid = 0;
    applyCpl(s);
    checkState();
  endtask

  task automatic doProgram(input int s, input int sl, input logic [15:0] a);
    @(negedge clk);
    progValid = 1; progSet = 3'(s); progSlot = 2'(sl); progAddr = a;
    @(posedge clk); @(negedge clk);
    progValid = 0;
    mAddr[s][sl] = a;
    for (int i = 0; i < 2; i++) mEn[i][s][sl] = 1;
  endtask

  // cplAt: edge number after the accepting edge at which a completion is sent (-1: none)
  task automatic doRequest(input int cnt, input logic [7:0] tag, input int cplAt, input int cplS);
    bit conf [2];
    bit expG [2];
    int expS [2];
    for (int i = 0; i < 2; i++) begin
      conf[i] = 0;
      for (int s = gOff[i]; s < gOff[i] + gN[i]; s++)
        if (mInUse[i][s])
          for (int sl = 0; sl < CPS; sl++)
            if (mEn[i][s][sl])
              for (int k = 0; k < cnt; k++)
                if (mAddr[s][sl] == rq[k]) conf[i] = 1;
    end
    @(negedge clk);
    for (int c = 0; c <= 15; c++) begin
      if (c == 0) begin
        reqValid = 1; reqCount = 5'(cnt); reqTag = tag;
        for (int k = 0; k < NREQ; k++) reqAddrs[k*16 +: 16] = rq[k];
      end
      if (c == 3) begin
        // stray request while busy: must be ignored (R9)
        reqValid = 1; reqCount = 5'd16; reqTag = ~tag; reqAddrs = '1;
      end
      if (c == cplAt) begin cplValid = 1; cplSet = 3'(cplS); end
      @(posedge clk); @(negedge clk);
      reqValid = 0; cplValid = 0;
      for (int i = 0; i < 2; i++) begin
        checkEq($sformatf("R9 reqReady inst%0d edge%0d", i, c), int'(reqReadyX[i]), int'(c >= lat[i]));
        if (c == lat[i]) begin
          expG[i] = 0; expS[i] = 0;
          if (!conf[i])
            for (int s = gOff[i] + gN[i] - 1; s >= gOff[i]; s--)
              if (!mInUse[i][s]) begin expG[i] = 1; expS[i] = s; end
          checkEq($sformatf("R9 doneValid inst%0d", i), int'(doneValidX[i]), 1);
          checkEq($sformatf("R3/R4 doneGrant inst%0d", i), int'(doneGrantX[i]), int'(expG[i]));
          checkEq($sformatf("R2/R4 doneSet inst%0d", i), int'(doneSetX[i]), expS[i]);
        end else begin
          checkEq($sformatf("R9 no doneValid inst%0d edge%0d", i, c), int'(doneValidX[i]), 0);
        end
      end
      if (c == cplAt) applyCpl(cplS);   // R11: decision above used the pre-completion state
      for (int i = 0; i < 2; i++)
        if (c == lat[i] && expG[i]) begin
          mInUse[i][expS[i]] = 1;
          mTag[i][expS[i]] = tag;
          if (borrow[i]) begin
            mIrq[i][expS[i]] = 1;
            for (int sl = 0; sl < CPS; sl++) mEn[i][expS[i]][sl] = 0;
          end
        end
    end
    checkState();
  endtask

  task automatic setReq(input logic [15:0] a0, input logic [15:0] a1);
    for (int k = 0; k < NREQ; k++) rq[k] = 16'h0F00 + 16'(k);
    rq[0] = a0; rq[1] = a1;
  endtask

  initial begin
    for (int i = 0; i < 2; i++)
      for (int s = 0; s < SETS; s++) begin
        mInUse[i][s] = 0; mTag[i][s] = 0;
        mIrq[i][s] = (!borrow[i] && s >= gOff[i] && s < gOff[i] + gN[i]);
        for (int sl = 0; sl < CPS; sl++) mEn[i][s][sl] = 0;
      end
    for (int s = 0; s < SETS; s++)
      for (int sl = 0; sl < CPS; sl++) mAddr[s][sl] = 16'hFFFF;

    repeat (3) @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 2; i++) begin
      checkEq($sformatf("R1 reqReady inst%0d", i), int'(reqReadyX[i]), 1);
      checkEq($sformatf("R1 doneValid inst%0d", i), int'(doneValidX[i]), 0);
      checkEq($sformatf("R1 groupBusy inst%0d", i), int'(groupBusyX[i]), 0);
    end
    checkEq("R1 irqEn own group", int'(irqEnX[0]), 8'h03);
    checkEq("R1 irqEn borrowing", int'(irqEnX[1]), 8'h00);
    rstN = 1;
    @(negedge clk);

    // R7: stale wake enable on set 2 does not block, and is wiped on borrow
    doProgram(2, 1, 16'h0055);
    setReq(16'h0055, 16'h0055);
    doRequest(1, 8'hA1, -1, 0);
    doRequest(1, 8'hA2, -1, 0);
    // R3: conflict against an enabled command of a held set
    doProgram(0, 2, 16'h0077);
    setReq(16'h0010, 16'h0077);
    doRequest(2, 8'hA3, -1, 0);
    // R6/R5: releases
    doComplete(1);
    doComplete(3);
    // R3: address beyond reqCount ignored
    setReq(16'h0001, 16'h0077);
    doRequest(1, 8'hA4, -1, 0);
    // R11: completion at the decision edge of the own-group instance
    setReq(16'h0002, 16'h0002);
    doRequest(1, 8'hA5, 9, 0);
    setReq(16'h0003, 16'h0003);
    doRequest(1, 8'hA6, -1, 0);

    // near-exhaustive sweep over a small address pool
    for (int it = 0; it < 80; it++) begin
      int op = int'(nextRand() % 4);
      if (op == 0) begin
        doProgram(int'(nextRand() % 5), int'(nextRand() % CPS), 16'h0020 + 16'(nextRand() % 6));
      end else if (op == 1) begin
        doComplete(int'(nextRand() % 5));
      end else begin
        int cnt = (nextRand() % 8 == 0) ? 16 : int'(1 + nextRand() % 3);
        for (int k = 0; k < NREQ; k++) rq[k] = 16'h0020 + 16'(nextRand() % 6);
        doRequest(cnt, 8'(nextRand()), -1, 0);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule